// File: doc/BRIEF.md
# Synchronous Serial Master

This block is a register-mapped serial master for SPI peripherals. Software sets the frame length, the clock polarity and phase, and a two-stage bit-rate divider. Frames written to the data register queue in an eight-entry transmit FIFO. The shifter takes each queued frame in turn and drives it out most significant bit first on `mosi`, with `sclk` as the bit clock. Each frame captured at the same time from `miso` lands in an eight-entry receive FIFO, and reads of the data register drain that FIFO.

Three interrupt sources, each with its own enable, feed a single `irq` line. They are transmit-FIFO low water, receive-FIFO high water, and a sticky receive-overrun flag. A loopback switch feeds the transmit bit stream back into the receiver inside the block so that software can test the block on its own. Slave selects are not generated here.

The bus uses word addressing: `bus_addr` is the byte offset divided by four. Write data is taken on the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `ssp_master`

## Requirements
- R1: After reset, the status word (index 3) reads 0x0003, the interrupt word (index 5) reads 0, the format word (index 0) reads 0 and the prescale word (index 4) reads 2. `sclk`, `mosi` and `irq` are low.
- R2: The format word holds the frame size code in bits [3:0], equal to bits per frame minus one, for 4 to 16 bits (codes below 3 act as 3). Frames shift MSB first. Received frames read back right-aligned with zero upper bits. Transmit bits above the frame size are ignored.
- R3: Format bit 7 sets the idle level of `sclk`. With format bit 6 clear, data is sampled on the first edge of each bit and changed on the second edge. With format bit 6 set, data is changed on the first edge and sampled on the second edge.
- R4: Each `sclk` half period lasts (P/2)·(S+1) clock cycles. S is format bits [15:8]. P is the prescale word: bit 0 always reads 0, and a written value below 2 is stored as 2.
- R5: Each FIFO holds 8 frames. Writing data (index 2) pushes the transmit FIFO, and a write to a full transmit FIFO is dropped. Reading data pops the receive FIFO, and reading an empty receive FIFO returns 0.
- R6: Status bits: [0] transmit FIFO empty, [1] transmit FIFO not full, [2] receive FIFO not empty, [3] receive FIFO full, [4] busy.
- R7: A frame that completes while the receive FIFO is full is discarded and sets the overrun flag. The flag holds until any write to index 5 clears it.
- R8: The interrupt word reports: bit 0 = control bit 0 and receive count ≥ 4; bit 1 = control bit 1 and transmit count ≤ 4; bit 2 = control bit 2 and the overrun flag.
- R9: `irq` is high one cycle after any bit of the interrupt word is high, and low one cycle after all of them are low.
- R10: With control (index 1) bit 3 set, the receiver takes the transmit bit stream and `miso` has no effect.
- R11: Frames shift only while control bit 4 is set. Clearing it abandons the current frame, and `sclk` is at its idle level on the following cycle.
- R12: Busy is high while a frame is shifting or the transmit FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench runs a model slave that captures `mosi` and drives `miso` in all four clock modes. It also times the interval between `sclk` edges. A swapped phase would therefore show up as a shifted capture, and a divider off by one step as a wrong interval. The bench overfills both FIFOs. A full-FIFO check placed in the wrong spot would either let a ninth frame overwrite the first or raise an overrun where none occurred. It walks the receive count across the half-depth threshold, clears the sticky overrun, and drops enable in the middle of a slow frame. A design that left `sclk` parked mid-frame there, or pushed a partial frame, would be caught.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int FRAME_W = 16;
  localparam int SIZE_W  = 4;
  localparam int REG_AW  = 3;
  localparam int DIV_W   = 8;

  typedef enum logic [REG_AW-1:0] {
    RG_FMT   = 3'd0,
    RG_CTL   = 3'd1,
    RG_DATA  = 3'd2,
    RG_STAT  = 3'd3,
    RG_PRESC = 3'd4,
    RG_INT   = 3'd5
  } reg_e;

  localparam int C1_RXIE = 0;
  localparam int C1_TXIE = 1;
  localparam int C1_ORIE = 2;
  localparam int C1_LOOP = 3;
  localparam int C1_EN   = 4;
  localparam int C1_W    = 5;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [WIDTH-1:0]               wdata,
  input  logic                           pop,
  output logic [WIDTH-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           empty,
  output logic                           full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int PRE_W  = 7,
  parameter int POST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PRE_W-1:0]  half_pre,
  input  logic [POST_W-1:0] post,
  output logic              tick
);
  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic [PRE_W-1:0]  pre_max;
  logic              pre_wrap;

  assign pre_max  = half_pre - 1'b1;
  assign pre_wrap = (pre_cnt == pre_max);
  assign tick     = run && pre_wrap && (post_cnt == post);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      post_cnt <= (post_cnt == post) ? '0 : post_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int FRAME_W = 16,
  parameter int SIZE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               loopback,
  input  logic [SIZE_W-1:0]  size,
  input  logic               miso,
  input  logic               tx_avail,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               tick,
  output logic               tx_take,
  output logic               rx_done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               active,
  output logic               sclk_o,
  output logic               mosi_o
);
  localparam int CNT_W = SIZE_W + 1;
  localparam logic [SIZE_W-1:0] TOP = SIZE_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] tx_sh, rx_sh, mask;
  logic [CNT_W-1:0]   ecnt, last;
  logic               rx_in, leading, do_sample, do_shift;

  assign last      = {size, 1'b1};
  assign rx_in     = loopback ? tx_sh[FRAME_W-1] : miso;
  assign leading   = !ecnt[0];
  assign do_sample = cpha ? !leading : leading;
  assign do_shift  = cpha ? (leading && (ecnt != '0)) : !leading;
  assign tx_take   = en && !active && tx_avail;
  assign rx_done   = en && active && tick && (ecnt == last);
  assign mask      = {FRAME_W{1'b1}} >> (TOP - size);
  assign rx_word   = (cpha ? {rx_sh[FRAME_W-2:0], rx_in} : rx_sh) & mask;
  assign mosi_o    = tx_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk_o <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      ecnt   <= '0;
    end else if (!en) begin
      active <= 1'b0;
      sclk_o <= cpol;
      ecnt   <= '0;
    end else if (!active) begin
      sclk_o <= cpol;
      ecnt   <= '0;
      if (tx_avail) begin
        active <= 1'b1;
        tx_sh  <= tx_word << (TOP - size);
        rx_sh  <= '0;
      end
    end else if (tick) begin
      sclk_o <= !sclk_o;
      ecnt   <= ecnt + 1'b1;
      if (do_sample) rx_sh <= {rx_sh[FRAME_W-2:0], rx_in};
      if (do_shift)  tx_sh <= tx_sh << 1;
      if (ecnt == last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int HALF  = FIFO_DEPTH / 2;

  logic [SIZE_W-1:0]  size_q, size_eff;
  logic               cpha_q, cpol_q;
  logic [DIV_W-1:0]   scr_q;
  logic [DIV_W-2:0]   half_q;
  logic [C1_W-1:0]    ctl_q;
  logic               ovr_q;

  logic               tx_take, tx_empty, tx_full;
  logic [FRAME_W-1:0] tx_head;
  logic [CNT_W-1:0]   tx_cnt;
  logic               rx_done, rx_empty, rx_full, rx_pop;
  logic [FRAME_W-1:0] rx_word, rx_head;
  logic [CNT_W-1:0]   rx_cnt;
  logic               active, tick, port_en, int_clr;
  logic               rx_req, tx_req, ovr_req, busy;
  logic [FRAME_W-1:0] fmt_word, stat_word, int_word;

  assign port_en  = ctl_q[C1_EN];
  assign size_eff = (size_q < SIZE_W'(3)) ? SIZE_W'(3) : size_q;
  assign int_clr  = bus_wr && (bus_addr == RG_INT);
  assign rx_pop   = bus_rd && (bus_addr == RG_DATA) && !rx_empty;
  assign busy     = active || !tx_empty;
  assign rx_req   = ctl_q[C1_RXIE] && (rx_cnt >= CNT_W'(HALF));
  assign tx_req   = ctl_q[C1_TXIE] && (tx_cnt <= CNT_W'(HALF));
  assign ovr_req  = ctl_q[C1_ORIE] && ovr_q;

  assign fmt_word  = {scr_q, cpol_q, cpha_q, 2'b00, size_q};
  assign stat_word = {{(FRAME_W-5){1'b0}}, busy, rx_full, !rx_empty, !tx_full, tx_empty};
  assign int_word  = {{(FRAME_W-3){1'b0}}, ovr_req, tx_req, rx_req};

  ssp_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(bus_wr && (bus_addr == RG_DATA)), .wdata(bus_wdata),
    .pop(tx_take), .rdata(tx_head),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  ssp_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_done), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  ssp_clkdiv #(.PRE_W(DIV_W-1), .POST_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(active),
    .half_pre(half_q), .post(scr_q), .tick(tick)
  );

  ssp_shifter #(.FRAME_W(FRAME_W), .SIZE_W(SIZE_W)) u_shift (
    .clk(clk), .rst(rst), .en(port_en),
    .cpol(cpol_q), .cpha(cpha_q), .loopback(ctl_q[C1_LOOP]),
    .size(size_eff), .miso(miso),
    .tx_avail(!tx_empty), .tx_word(tx_head), .tick(tick),
    .tx_take(tx_take), .rx_done(rx_done), .rx_word(rx_word),
    .active(active), .sclk_o(sclk), .mosi_o(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
      scr_q  <= '0;
      half_q <= (DIV_W-1)'(1);
      ctl_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        RG_FMT: begin
          size_q <= bus_wdata[SIZE_W-1:0];
          cpha_q <= bus_wdata[6];
          cpol_q <= bus_wdata[7];
          scr_q  <= bus_wdata[15:8];
        end
        RG_CTL:   ctl_q  <= bus_wdata[C1_W-1:0];
        RG_PRESC: half_q <= (bus_wdata[7:1] == '0) ? (DIV_W-1)'(1) : bus_wdata[7:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ovr_q <= 1'b0;
    else if (rx_done && rx_full) ovr_q <= 1'b1;
    else if (int_clr) ovr_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |int_word;
      if (bus_rd) begin
        case (bus_addr)
          RG_FMT:   bus_rdata <= fmt_word;
          RG_CTL:   bus_rdata <= {{(FRAME_W-C1_W){1'b0}}, ctl_q};
          RG_DATA:  bus_rdata <= rx_empty ? '0 : rx_head;
          RG_STAT:  bus_rdata <= stat_word;
          RG_PRESC: bus_rdata <= {{(FRAME_W-DIV_W){1'b0}}, half_q, 1'b0};
          RG_INT:   bus_rdata <= int_word;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          rx_done,
  input logic          rx_full,
  input logic          ovr_q,
  input logic          int_clr,
  input logic          enable,
  input logic          cpol,
  input logic          sclk
);
  // R5
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CW'(DEPTH));

  // R5
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= CW'(DEPTH));

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full) |=> ovr_q);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !int_clr) |=> ovr_q);

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (int_clr && !(rx_done && rx_full)) |=> !ovr_q);

  // R11
  idle_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (sclk == $past(cpol)));
endmodule

bind ssp_master ssp_master_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .rx_done(rx_done), .rx_full(rx_full), .ovr_q(ovr_q),
  .int_clr(int_clr), .enable(port_en), .cpol(cpol_q), .sclk(sclk)
);

// File: tb/ssp_master_test.sv
module ssp_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sclk, mosi, miso, irq;

  int checks = 0, errors = 0;

  always #4 clk = !clk;

  ssp_master uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  // ---- model slave: owned by one process, steered by s_arm / s_* ----
  logic        s_arm = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_prev = 1'b0, s_lead;
  int          s_n = 8, s_e = 0, t_last = 0, half_meas = 0, cyc = 0;
  logic [15:0] s_load = '0, s_out = '0, s_cap = '0, cap_last = '0;

  assign miso = s_out[15];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!s_arm) begin
      s_e   = 0;
      s_cap = '0;
      s_out = s_load << (16 - s_n);
    end else if (sclk !== s_prev) begin
      s_lead = (sclk != s_cpol);
      if (s_cpha ? !s_lead : s_lead) s_cap = {s_cap[14:0], mosi};
      if (s_cpha ? (s_lead && s_e != 0) : !s_lead) s_out = s_out << 1;
      if (s_e == 1) half_meas = cyc - t_last;
      t_last = cyc;
      s_e = s_e + 1;
      if (s_e == 2 * s_n) begin
        s_e      = 0;
        cap_last = s_cap;
        s_cap    = '0;
        s_out    = s_load << (16 - s_n);
      end
    end
    s_prev = sclk;
  end

  // ---- helpers ----
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    for (int i = 0; i < 3000; i++) begin
      bus_read(3'd3, st);
      if (!st[4]) break;
    end
  endtask

  typedef struct packed {
    logic        lb;
    logic [1:0]  mode;
    logic [3:0]  size;
    logic [7:0]  cpsr;
    logic [7:0]  scr;
    logic [15:0] tx;
    logic [15:0] sl;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 4'd7,  8'd2, 8'd0, 16'h00A5, 16'h003C},
    '{1'b0, 2'd1, 4'd15, 8'd4, 8'd1, 16'h1234, 16'hBEEF},
    '{1'b0, 2'd2, 4'd3,  8'd2, 8'd2, 16'h0009, 16'h0006},
    '{1'b0, 2'd3, 4'd11, 8'd6, 8'd0, 16'h0ABC, 16'h05A3},
    '{1'b1, 2'd0, 4'd4,  8'd2, 8'd3, 16'h0015, 16'h000A},
    '{1'b1, 2'd3, 4'd9,  8'd8, 8'd1, 16'h02AB, 16'h0155},
    '{1'b0, 2'd0, 4'd7,  8'd5, 8'd0, 16'hFF81, 16'h007E}
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, mask, exp_rx;
    int c, half;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1: reset values
    @(negedge clk);
    check("R1 sclk", {15'd0, sclk}, 16'd0);
    check("R1 mosi", {15'd0, mosi}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    bus_read(3'd3, v); check("R1 R6 status", v, 16'h0003);
    bus_read(3'd5, v); check("R1 int word", v, 16'h0000);
    bus_read(3'd0, v); check("R1 format", v, 16'h0000);
    bus_read(3'd4, v); check("R1 R4 prescale", v, 16'h0002);

    // table walk: R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); s_arm = 1'b0;
      bus_write(3'd1, 16'h0000);
      bus_write(3'd4, {8'd0, VEC[i].cpsr});
      bus_write(3'd0, {VEC[i].scr, VEC[i].mode[1], VEC[i].mode[0], 2'b00, VEC[i].size});
      bus_write(3'd1, {12'd0, VEC[i].lb, 3'b000});
      @(posedge clk);
      s_cpol = VEC[i].mode[1]; s_cpha = VEC[i].mode[0];
      s_n = int'(VEC[i].size) + 1; s_load = VEC[i].sl;
      repeat (3) @(posedge clk);
      s_arm = 1'b1;
      bus_write(3'd2, VEC[i].tx);
      bus_write(3'd1, {11'd0, 1'b1, VEC[i].lb, 3'b000});
      wait_idle();
      mask = 16'hFFFF >> (15 - VEC[i].size);
      exp_rx = VEC[i].lb ? (VEC[i].tx & mask) : (VEC[i].sl & mask);
      bus_read(3'd2, v);
      check(VEC[i].lb ? "R10 loopback rx" : "R2 R3 rx frame", v, exp_rx);
      check("R2 R3 mosi frame", cap_last, VEC[i].tx & mask);
      c = int'(VEC[i].cpsr & 8'hFE); if (c < 2) c = 2;
      half = (c / 2) * (int'(VEC[i].scr) + 1);
      check("R4 half period", 16'(half_meas), 16'(half));
    end
    @(posedge clk); s_arm = 1'b0;

    // R5 R6: fill transmit FIFO while disabled
    bus_write(3'd1, 16'h0000);
    bus_write(3'd0, 16'h0007);
    bus_write(3'd4, 16'h0002);
    for (int k = 1; k <= 9; k++) bus_write(3'd2, 16'(k));
    bus_read(3'd3, v); check("R5 R6 R12 tx full status", v, 16'h0010);
    bus_write(3'd1, 16'h0018);
    wait_idle();
    bus_read(3'd3, v); check("R6 rx full status", v, 16'h000F);
    bus_write(3'd1, 16'h001C);
    bus_read(3'd5, v); check("R5 dropped write no overrun", v, 16'h0000);
    bus_write(3'd1, 16'h0018);
    for (int k = 1; k <= 8; k++) begin
      bus_read(3'd2, v); check("R5 fifo order", v, 16'(k));
    end
    bus_read(3'd3, v); check("R6 drained status", v, 16'h0003);
    bus_read(3'd2, v); check("R5 empty read", v, 16'h0000);

    // R7 R8 R9: overrun with all requests enabled
    bus_write(3'd1, 16'h001F);
    for (int k = 0; k < 9; k++) bus_write(3'd2, 16'h0011 + 16'(k));
    wait_idle();
    bus_read(3'd5, v); check("R7 R8 overrun set", v, 16'h0007);
    check("R9 irq high", {15'd0, irq}, 16'd1);
    bus_read(3'd2, v); check("R7 oldest kept", v, 16'h0011);
    bus_write(3'd5, 16'h0000);
    bus_read(3'd5, v); check("R7 overrun cleared", v, 16'h0003);
    for (int k = 2; k <= 4; k++) bus_read(3'd2, v);
    bus_read(3'd5, v); check("R8 rx req at four", v, 16'h0003);
    bus_read(3'd2, v);
    bus_read(3'd5, v); check("R8 rx req below four", v, 16'h0002);
    for (int k = 6; k <= 8; k++) bus_read(3'd2, v);
    check("R7 last kept frame", v, 16'h0018);
    bus_write(3'd1, 16'h0018);
    bus_read(3'd5, v); check("R8 masked", v, 16'h0000);
    check("R9 irq low", {15'd0, irq}, 16'd0);

    // R8: transmit threshold
    bus_write(3'd1, 16'h0002);
    for (int k = 0; k < 4; k++) bus_write(3'd2, 16'h0040 + 16'(k));
    bus_read(3'd5, v); check("R8 tx req at four", v, 16'h0002);
    bus_write(3'd2, 16'h0044);
    bus_read(3'd5, v); check("R8 tx req above four", v, 16'h0000);
    bus_write(3'd1, 16'h001A);
    wait_idle();
    for (int k = 0; k < 5; k++) bus_read(3'd2, v);
    check("R10 loopback last", v, 16'h0044);

    // R11 R12: disable mid-frame, polarity high
    bus_write(3'd1, 16'h0008);
    bus_write(3'd0, 16'h0987);
    bus_write(3'd4, 16'd20);
    bus_write(3'd2, 16'h00C3);
    bus_write(3'd1, 16'h0018);
    bus_read(3'd3, v);
    check("R3 idle high before edge", {15'd0, sclk}, 16'd1);
    repeat (150) @(negedge clk);
    check("R4 second half period", {15'd0, sclk}, 16'd0);
    bus_read(3'd3, v); check("R12 busy while shifting", v, 16'h0013);
    bus_write(3'd1, 16'h0008);
    @(negedge clk);
    check("R11 sclk idle after disable", {15'd0, sclk}, 16'd1);
    bus_read(3'd3, v); check("R11 frame abandoned", v, 16'h0003);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule